// File: doc/BRIEF.md
# Four-Phase Handshake Transfer Controller

This block carries one parallel word at a time from a sending unit to a receiving unit when the two run from unrelated clocks. The only timing between them is two handshake wires and a shared data bus. A one-bit mode input picks the protocol. In the source-first protocol, the sender offers a word and the receiver acknowledges it. In the destination-first protocol, the receiver asks for a word and the sender answers.

The sending endpoint and the receiving endpoint are separate controllers, each clocked and reset in its own domain. Each endpoint passes the handshake wire it receives through a multi-stage synchronizer before acting on it. Every phase waits on the partner with no fixed delay, so the slower side sets the transfer rate.

A programmable cycle limit guards each waiting phase. If the partner stalls past that limit, the endpoint raises a sticky error, releases its wires and stops until it is reset. Local user logic on the sending side sees a valid/ready pair. Local user logic on the receiving side holds a ready level and gets a one-cycle strobe for each word it receives.

Top module: `hs_xfer_link`

## Requirements
- R1: The sender loads the word onto the link data bus at least one sending-clock cycle before it raises the valid wire, and keeps the word unchanged for as long as valid stays high.
- R2: Whenever the sender lowers the valid wire (normal completion or timeout), the link data bus reads all zeros from that cycle on.
- R3: In mode 0 (source-first), the receiver captures the bus on the cycle it sees valid high while its local ready is high. It gives a single-cycle `dst_valid` strobe with the word and raises the acknowledge wire in the same cycle. It lowers acknowledge only after it sees valid low again.
- R4: The sender lowers valid only after its synchronized copy of the acknowledge wire is high in mode 0, or low again in mode 1.
- R5: In mode 1 (destination-first), the receiver raises the acknowledge wire (here meaning "ready for data") only while its local ready is high and it sees valid low. The sender accepts a local word (`src_ready` high) only while it sees that wire high.
- R6: In mode 1, the receiver lowers the acknowledge wire in the same cycle as its `dst_valid` strobe.
- R7: Back-to-back words arrive exactly once and in order in both modes. In mode 0 the sender does not start a new word until it has seen the acknowledge wire low.
- R8: If an endpoint waits in one phase for more than `tmo_limit` of its own clock cycles, its error output rises and stays high until reset. Its handshake wire and (on the sender) its bus drop to zero, and it takes no further word (`src_ready` low).
- R9: A `tmo_limit` of zero disables the timeout, so an endpoint waits for its partner indefinitely.
- R10: After reset, the link wires and bus, both errors and `dst_valid` are low. In mode 0, `src_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Sending-side clock |
| rst_src_n | input | 1 | Sending-side asynchronous reset, active low |
| clk_dst | input | 1 | Receiving-side clock |
| rst_dst_n | input | 1 | Receiving-side asynchronous reset, active low |
| mode | input | 1 | 0 = source-first, 1 = destination-first; change only during reset |
| tmo_limit | input | TMO_W | Phase wait limit in local cycles; 0 disables the timeout |
| src_valid | input | 1 | Local sender has a word |
| src_data | input | DATA_W | Word offered by the local sender |
| src_ready | output | 1 | Sending endpoint takes the word this cycle |
| dst_ready | input | 1 | Local receiver can take a word |
| dst_valid | output | 1 | One-cycle strobe: `dst_data` holds a new word |
| dst_data | output | DATA_W | Last word received |
| link_valid | output | 1 | Valid wire, sender to receiver |
| link_ack | output | 1 | Acknowledge / ready-for-data wire, receiver to sender |
| link_data | output | DATA_W | Link data bus, zero when invalid |
| src_err | output | 1 | Sticky timeout error of the sending endpoint |
| dst_err | output | 1 | Sticky timeout error of the receiving endpoint |

## Verification
The bench builds the block with its default widths and clocks the sender at 200 MHz and the receiver at about 71 MHz. The receiving side is therefore the slower partner, and every synchronizer crossing spans several sending cycles. It runs with a wait limit of 20 cycles, so both endpoint timeouts fire within a few hundred cycles. It also runs with a wait limit of zero, which lets it hold the partner off for hundreds of cycles to show that stalls are tolerated rather than flagged.

// File: rtl/hs_xfer_pkg.sv
`timescale 1ns/1ps
package hs_xfer_pkg;

   // protocol selector carried on the mode pin
   typedef enum logic {
      HS_SRC_FIRST = 1'b0,
      HS_DST_FIRST = 1'b1
   } hs_mode_e;

   typedef enum logic [1:0] {
      SND_IDLE    = 2'd0,
      SND_SETUP   = 2'd1,
      SND_PRESENT = 2'd2,
      SND_RELEASE = 2'd3
   } snd_state_e;

   typedef enum logic [1:0] {
      RCV_IDLE = 2'd0,
      RCV_ASK  = 2'd1,
      RCV_HOLD = 2'd2
   } rcv_state_e;

endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
module hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   initial begin
      assert (STAGES >= 2) else $error("hs_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= d;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[g] <= 1'b0;
         else        chain_q[g] <= chain_q[g-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hs_timeout.sv
`timescale 1ns/1ps
module hs_timeout #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clear,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (CNT_W >= 2) else $error("hs_timeout: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run || clear)    cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign expire = run && (limit != '0) && (cnt_q >= limit);
endmodule

// File: rtl/hs_snd_ctrl.sv
`timescale 1ns/1ps
module hs_snd_ctrl
   import hs_xfer_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode,
   input  logic [TMO_W-1:0]  tmo_limit,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   output logic              s_ready,
   input  logic              ack_async,
   output logic              bus_valid,
   output logic [DATA_W-1:0] bus_data,
   output logic              err
);
   snd_state_e        state_q, state_d;
   logic              ack_s;
   logic              valid_q, err_q, fault, expire, take, partner_ok;
   logic [DATA_W-1:0] data_q;
   hs_mode_e          proto;

   assign proto = hs_mode_e'(mode);

   hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack_async), .q(ack_s)
   );

   hs_timeout #(.CNT_W(TMO_W)) u_tmo (
      .clk(clk), .rst_n(rst_n),
      .run((state_q == SND_PRESENT) || (state_q == SND_RELEASE)),
      .clear(state_d != state_q),
      .limit(tmo_limit),
      .expire(expire)
   );

   // source-first needs the acknowledge wire quiet; destination-first needs a request
   assign partner_ok = (proto == HS_DST_FIRST) ? ack_s : !ack_s;
   assign s_ready    = (state_q == SND_IDLE) && !err_q && partner_ok;
   assign take       = s_valid && s_ready;

   always_comb begin
      state_d = state_q;
      fault   = 1'b0;
      unique case (state_q)
         SND_IDLE:    if (take) state_d = SND_SETUP;
         SND_SETUP:   state_d = SND_PRESENT;
         SND_PRESENT: begin
            if (ack_s == (proto == HS_SRC_FIRST)) state_d = SND_RELEASE;
            else if (expire)                      fault   = 1'b1;
         end
         SND_RELEASE: begin
            if (!ack_s)      state_d = SND_IDLE;
            else if (expire) fault   = 1'b1;
         end
         default: state_d = SND_IDLE;
      endcase
      if (fault) state_d = SND_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SND_IDLE;
         valid_q <= 1'b0;
         data_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         valid_q <= (state_d == SND_PRESENT);
         err_q   <= err_q | fault;
         if (take)
            data_q <= s_data;
         else if ((state_d == SND_IDLE) || (state_d == SND_RELEASE))
            data_q <= '0;
      end
   end

   assign bus_valid = valid_q;
   assign bus_data  = data_q;
   assign err       = err_q;

   p_data_before_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> $stable(data_q))
      else $error("R1: bus changed while valid high");

   p_bus_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(valid_q) |-> (data_q == '0))
      else $error("R2: bus not invalidated");

   p_valid_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(valid_q) && !$rose(err_q)) |-> ($past(ack_s) == (proto == HS_SRC_FIRST)))
      else $error("R4: valid dropped without partner response");

   p_no_stale_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(valid_q) && (proto == HS_SRC_FIRST)) |-> !$past(ack_s))
      else $error("R7: new word offered while acknowledge seen high");

   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q)
      else $error("R8: error cleared without reset");

   p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (!valid_q && !s_ready))
      else $error("R8: sender active after error");

   p_no_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((tmo_limit == '0) && !err_q) |=> !err_q)
      else $error("R9: timeout with limit zero");
endmodule

// File: rtl/hs_rcv_ctrl.sv
`timescale 1ns/1ps
module hs_rcv_ctrl
   import hs_xfer_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode,
   input  logic [TMO_W-1:0]  tmo_limit,
   input  logic              d_ready,
   output logic              d_valid,
   output logic [DATA_W-1:0] d_data,
   input  logic              valid_async,
   input  logic [DATA_W-1:0] bus_data,
   output logic              ack,
   output logic              err
);
   rcv_state_e        state_q, state_d;
   logic              valid_s, expire, fault, capture;
   logic              ack_q, dv_q, err_q;
   logic [DATA_W-1:0] word_q;
   hs_mode_e          proto;

   assign proto = hs_mode_e'(mode);

   hs_sync #(.STAGES(SYNC_STAGES)) u_valid_sync (
      .clk(clk), .rst_n(rst_n), .d(valid_async), .q(valid_s)
   );

   hs_timeout #(.CNT_W(TMO_W)) u_tmo (
      .clk(clk), .rst_n(rst_n),
      .run((state_q == RCV_ASK) || (state_q == RCV_HOLD)),
      .clear(state_d != state_q),
      .limit(tmo_limit),
      .expire(expire)
   );

   always_comb begin
      state_d = state_q;
      fault   = 1'b0;
      capture = 1'b0;
      unique case (state_q)
         RCV_IDLE: begin
            if (!err_q && d_ready) begin
               if (proto == HS_SRC_FIRST) begin
                  if (valid_s) begin
                     capture = 1'b1;
                     state_d = RCV_HOLD;
                  end
               end else if (!valid_s) begin
                  state_d = RCV_ASK;
               end
            end
         end
         RCV_ASK: begin
            if (valid_s) begin
               capture = 1'b1;
               state_d = RCV_HOLD;
            end else if (expire) begin
               fault = 1'b1;
            end
         end
         RCV_HOLD: begin
            if (!valid_s)    state_d = RCV_IDLE;
            else if (expire) fault   = 1'b1;
         end
         default: state_d = RCV_IDLE;
      endcase
      if (fault) state_d = RCV_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RCV_IDLE;
         ack_q   <= 1'b0;
         dv_q    <= 1'b0;
         err_q   <= 1'b0;
         word_q  <= '0;
      end else begin
         state_q <= state_d;
         ack_q   <= (state_d == RCV_ASK) ||
                    ((state_d == RCV_HOLD) && (proto == HS_SRC_FIRST));
         dv_q    <= capture;
         err_q   <= err_q | fault;
         if (capture) word_q <= bus_data;
      end
   end

   assign ack     = ack_q;
   assign d_valid = dv_q;
   assign d_data  = word_q;
   assign err     = err_q;

   p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dv_q |=> !dv_q)
      else $error("R3: receive strobe longer than one cycle");

   p_accept_with_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dv_q && (proto == HS_SRC_FIRST)) |-> ack_q)
      else $error("R3: accept not raised with capture");

   p_accept_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ack_q) && (proto == HS_SRC_FIRST) && !$rose(err_q)) |-> !$past(valid_s))
      else $error("R3: accept dropped while valid seen high");

   p_request_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ack_q) && (proto == HS_DST_FIRST)) |-> $past(d_ready && !valid_s))
      else $error("R5: request raised without local ready or with valid high");

   p_request_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dv_q && (proto == HS_DST_FIRST)) |-> !ack_q)
      else $error("R6: request still high at capture");

   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q)
      else $error("R8: error cleared without reset");

   p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (!ack_q && !dv_q))
      else $error("R8: receiver active after error");

   p_no_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((tmo_limit == '0) && !err_q) |=> !err_q)
      else $error("R9: timeout with limit zero");
endmodule

// File: rtl/hs_xfer_link.sv
`timescale 1ns/1ps
module hs_xfer_link #(
   parameter int DATA_W      = 8,
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_src,
   input  logic              rst_src_n,
   input  logic              clk_dst,
   input  logic              rst_dst_n,
   input  logic              mode,
   input  logic [TMO_W-1:0]  tmo_limit,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ready,
   input  logic              dst_ready,
   output logic              dst_valid,
   output logic [DATA_W-1:0] dst_data,
   output logic              link_valid,
   output logic              link_ack,
   output logic [DATA_W-1:0] link_data,
   output logic              src_err,
   output logic              dst_err
);
   initial begin
      assert (DATA_W >= 1) else $error("hs_xfer_link: DATA_W must be positive");
      assert (TMO_W >= 2 && TMO_W <= 32) else $error("hs_xfer_link: TMO_W out of range");
      assert (SYNC_STAGES >= 2) else $error("hs_xfer_link: SYNC_STAGES below 2");
   end

   logic              w_valid, w_ack;
   logic [DATA_W-1:0] w_data;

   hs_snd_ctrl #(
      .DATA_W(DATA_W), .TMO_W(TMO_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_snd (
      .clk(clk_src), .rst_n(rst_src_n), .mode(mode), .tmo_limit(tmo_limit),
      .s_valid(src_valid), .s_data(src_data), .s_ready(src_ready),
      .ack_async(w_ack), .bus_valid(w_valid), .bus_data(w_data), .err(src_err)
   );

   hs_rcv_ctrl #(
      .DATA_W(DATA_W), .TMO_W(TMO_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_rcv (
      .clk(clk_dst), .rst_n(rst_dst_n), .mode(mode), .tmo_limit(tmo_limit),
      .d_ready(dst_ready), .d_valid(dst_valid), .d_data(dst_data),
      .valid_async(w_valid), .bus_data(w_data), .ack(w_ack), .err(dst_err)
   );

   assign link_valid = w_valid;
   assign link_ack   = w_ack;
   assign link_data  = w_data;
endmodule

// File: tb/tb_hs_xfer_link.sv
`timescale 1ns/1ps
module tb_hs_xfer_link;
   localparam int DW = 8;
   localparam int TW = 16;

   logic          clk_src = 1'b0, clk_dst = 1'b0;
   logic          rst_src_n = 1'b0, rst_dst_n = 1'b0;
   logic          mode = 1'b0;
   logic [TW-1:0] tmo_limit = '0;
   logic          src_valid = 1'b0;
   logic [DW-1:0] src_data = '0;
   logic          src_ready;
   logic          dst_ready = 1'b0;
   logic          dst_valid;
   logic [DW-1:0] dst_data;
   logic          link_valid, link_ack;
   logic [DW-1:0] link_data;
   logic          src_err, dst_err;

   always #2.5 clk_src = ~clk_src;
   always #7   clk_dst = ~clk_dst;

   hs_xfer_link #(.DATA_W(DW), .TMO_W(TW), .SYNC_STAGES(2)) dut (
      .clk_src(clk_src), .rst_src_n(rst_src_n), .clk_dst(clk_dst), .rst_dst_n(rst_dst_n),
      .mode(mode), .tmo_limit(tmo_limit),
      .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
      .dst_ready(dst_ready), .dst_valid(dst_valid), .dst_data(dst_data),
      .link_valid(link_valid), .link_ack(link_ack), .link_data(link_data),
      .src_err(src_err), .dst_err(dst_err)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [DW-1:0] rx_mem [16];
   int rx_n = 0;
   logic prev_v = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // R4: at the valid fall the acknowledge wire shows the partner's completed phase
   always @(negedge clk_src) begin
      if (rst_src_n) begin
         if (prev_v && !link_valid && !src_err)
            chk(link_ack == !mode, "R4 ack at valid fall", link_ack, !mode);
         prev_v = link_valid;
      end else begin
         prev_v = 1'b0;
      end
   end

   // R3 / R6: acknowledge level at the receive strobe; record words for R7
   always @(negedge clk_dst) begin
      if (rst_dst_n && dst_valid) begin
         if (mode) chk(link_ack == 1'b0, "R6 request low at capture", link_ack, 0);
         else      chk(link_ack == 1'b1, "R3 accept high at capture", link_ack, 1);
         if (rx_n < 16) rx_mem[rx_n] = dst_data;
         rx_n++;
      end
   end

   task automatic do_reset(input logic m, input int lim, input logic rdy);
      rst_src_n = 1'b0;
      rst_dst_n = 1'b0;
      src_valid = 1'b0;
      src_data  = '0;
      dst_ready = rdy;
      mode      = m;
      tmo_limit = TW'(lim);
      repeat (4) @(negedge clk_dst);
      rx_n = 0;
      @(negedge clk_src) rst_src_n = 1'b1;
      @(negedge clk_dst) rst_dst_n = 1'b1;
      repeat (4) @(negedge clk_src);
   endtask

   task automatic push_word(input logic [DW-1:0] w);
      @(negedge clk_src);
      src_valid = 1'b1;
      src_data  = w;
      for (int i = 0; i < 4000; i++) begin
         if (src_ready) begin
            @(posedge clk_src);
            @(negedge clk_src);
            break;
         end
         @(negedge clk_src);
      end
      src_valid = 1'b0;
      src_data  = '0;
   endtask

   task automatic send_word(input logic [DW-1:0] w);
      push_word(w);
      for (int i = 0; i < 400 && !link_valid; i++) @(negedge clk_src);
      chk(link_data == w, "R1 word on bus with valid", link_data, w);
      for (int i = 0; i < 4000 && link_valid; i++) @(negedge clk_src);
      chk(link_data == '0, "R2 bus cleared after valid", link_data, 0);
   endtask

   task automatic wait_rx(input int n);
      for (int i = 0; i < 4000 && rx_n < n; i++) @(negedge clk_dst);
   endtask

   task automatic t_reset();
      do_reset(1'b0, 0, 1'b0);
      chk(src_ready == 1'b1, "R10 src_ready after reset", src_ready, 1);
      chk(link_valid == 1'b0, "R10 link_valid after reset", link_valid, 0);
      chk(link_ack == 1'b0, "R10 link_ack after reset", link_ack, 0);
      chk(link_data == '0, "R10 link_data after reset", link_data, 0);
      chk(!src_err && !dst_err, "R10 errors after reset", {src_err, dst_err}, 0);
      chk(dst_valid == 1'b0, "R10 dst_valid after reset", dst_valid, 0);
   endtask

   task automatic t_stream(input logic m);
      logic [DW-1:0] pat [4];
      if (m) begin pat[0] = 8'h5A; pat[1] = 8'hC3; pat[2] = 8'h80; pat[3] = 8'h00; end
      else   begin pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'hFF; pat[3] = 8'h01; end
      do_reset(m, 0, 1'b1);
      foreach (pat[i]) send_word(pat[i]);
      wait_rx(4);
      repeat (40) @(negedge clk_dst);
      chk(rx_n == 4, "R7 word count", rx_n, 4);
      foreach (pat[i]) chk(rx_mem[i] == pat[i], "R7 word order", rx_mem[i], pat[i]);
      chk(!src_err && !dst_err, "R7 no error in stream", {src_err, dst_err}, 0);
   endtask

   task automatic t_si_stall();
      do_reset(1'b0, 0, 1'b0);
      push_word(8'h96);
      repeat (300) @(negedge clk_src);
      chk(link_valid == 1'b1, "R3 valid held while receiver busy", link_valid, 1);
      chk(link_ack == 1'b0, "R3 no accept while not ready", link_ack, 0);
      chk(rx_n == 0, "R3 no capture while not ready", rx_n, 0);
      chk(src_err == 1'b0, "R9 no timeout with limit zero", src_err, 0);
      @(negedge clk_dst) dst_ready = 1'b1;
      wait_rx(1);
      repeat (30) @(negedge clk_dst);
      chk(rx_n == 1 && rx_mem[0] == 8'h96, "R3 word after stall", rx_mem[0], 8'h96);
      chk(link_valid == 1'b0 && link_ack == 1'b0, "R3 wires idle after word",
          {link_valid, link_ack}, 0);
   endtask

   task automatic t_di_gate();
      do_reset(1'b1, 0, 1'b0);
      @(negedge clk_src);
      src_valid = 1'b1;
      src_data  = 8'h4D;
      repeat (60) begin
         @(negedge clk_src);
         if (src_ready) chk(1'b0, "R5 sender took word without request", 1, 0);
      end
      chk(link_ack == 1'b0, "R5 no request while receiver not ready", link_ack, 0);
      chk(link_valid == 1'b0, "R5 no valid without request", link_valid, 0);
      src_valid = 1'b0;
      @(negedge clk_dst) dst_ready = 1'b1;
      repeat (10) @(negedge clk_dst);
      chk(link_ack == 1'b1, "R5 request raised when ready", link_ack, 1);
      send_word(8'h4D);
      wait_rx(1);
      chk(rx_n == 1 && rx_mem[0] == 8'h4D, "R5 word after request", rx_mem[0], 8'h4D);
   endtask

   task automatic t_si_timeout();
      do_reset(1'b0, 20, 1'b0);
      push_word(8'h33);
      repeat (8) @(negedge clk_src);
      chk(src_err == 1'b0 && link_valid == 1'b1, "R8 no error before limit",
          {src_err, link_valid}, 1);
      repeat (200) @(negedge clk_src);
      chk(src_err == 1'b1, "R8 sender error after stall", src_err, 1);
      chk(link_valid == 1'b0, "R8 valid dropped on error", link_valid, 0);
      chk(link_data == '0, "R2 bus cleared on error", link_data, 0);
      chk(src_ready == 1'b0, "R8 sender halted", src_ready, 0);
      chk(dst_err == 1'b0, "R8 receiver unaffected", dst_err, 0);
      @(negedge clk_dst) dst_ready = 1'b1;
      repeat (60) @(negedge clk_dst);
      chk(rx_n == 0, "R8 abandoned word not delivered", rx_n, 0);
      chk(src_err == 1'b1, "R8 error sticky", src_err, 1);
   endtask

   task automatic t_di_timeout();
      do_reset(1'b1, 20, 1'b1);
      repeat (10) @(negedge clk_dst);
      chk(link_ack == 1'b1 && dst_err == 1'b0, "R8 request pending before limit",
          {link_ack, dst_err}, 2);
      repeat (100) @(negedge clk_dst);
      chk(dst_err == 1'b1, "R8 receiver error after stall", dst_err, 1);
      chk(link_ack == 1'b0, "R8 request dropped on error", link_ack, 0);
      repeat (40) @(negedge clk_dst);
      chk(link_ack == 1'b0 && dst_err == 1'b1, "R8 receiver stays halted",
          {link_ack, dst_err}, 1);
      chk(src_err == 1'b0, "R8 sender unaffected", src_err, 0);
   endtask

   task automatic t_no_limit();
      do_reset(1'b1, 0, 1'b1);
      repeat (300) @(negedge clk_dst);
      chk(dst_err == 1'b0, "R9 no receiver timeout with limit zero", dst_err, 0);
      chk(link_ack == 1'b1, "R9 request still pending", link_ack, 1);
      send_word(8'hE7);
      wait_rx(1);
      chk(rx_n == 1 && rx_mem[0] == 8'hE7, "R9 word after long wait", rx_mem[0], 8'hE7);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_stream(1'b0);
      t_stream(1'b1);
      t_si_stall();
      t_di_gate();
      t_si_timeout();
      t_di_timeout();
      t_no_limit();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule